// File: doc/BRIEF.md
# Parallel Column Readout Serializer

This block drains bit-serial data from the columns of a pixel matrix and merges it onto a single serial stream. The columns are handled in groups of k adjacent columns, in ascending index order, and k is chosen at run time. While a group is active, the block produces a column shift enable once every k readout-clock cycles. One bit is taken from each column of the group per shift period, and those k bits are sent out one per readout-clock cycle. The column shift rate is therefore the readout clock divided by k, and the serial output runs at the full readout-clock rate.

Column data is compressed, so the columns in a group can hold different numbers of bits. A column that has shown its last bit supplies filler zeros and receives no further shift enables. The group stays active until every one of its columns has finished, so the longest column sets how long the group lasts. The serial bits are also packed into bytes for a line encoder that follows. After the final group, a partial byte is padded and flushed, and a one-cycle completion pulse is raised.

Top module: `colrd_serializer`

## Requirements
- R1: `par_sel` selects the group width k (0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8). The value is captured when a run starts. Groups are k adjacent columns, taken from column 0 upward. `NUM_COLS` must be a multiple of 8.
- R2: While a group is active, `col_shift` is nonzero only on the last cycle of each k-cycle shift period. On that cycle it carries one bit for each column of the current group that has not yet finished. In every other cycle `col_shift` is zero.
- R3: While `ser_valid` is high, one bit is issued per cycle. In phase p of a shift period, `ser_out` carries the current bit of column base+p, so the bits go from the lowest to the highest column of the group.
- R4: After a column's bit with `col_last` high has been consumed, that column yields 0 on `ser_out` for the rest of the group. It gets no further shift enables, so each column receives exactly as many shifts as it holds bits.
- R5: A group lasts k times the bit count of its longest column, in cycles. The block moves to the next group only when every column in the group has finished.
- R6: Serial bits are packed MSB-first. The bit sent first lands in `byte_out[7]`. `byte_valid` is high for one cycle, in the cycle after the eighth bit of the byte.
- R7: After the last group, a partial byte is emitted with its unused low bits set to zero. No byte is emitted if no bits are pending.
- R8: `done` is high for exactly one cycle, three cycles after the last serial bit. In that cycle `busy` is already low, and every byte has been emitted.
- R9: A `start` pulse while `busy` is high is ignored, along with any change of `par_sel` during the run. The output streams are unchanged.
- R10: Synchronous active-high `rst` returns the block to idle and empties the byte packer. A run that follows starts cleanly from column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a readout run (taken only when idle) |
| par_sel | input | 2 | Group width select, k = 2^par_sel |
| col_data | input | NUM_COLS | Current bit presented by each column |
| col_last | input | NUM_COLS | High when that column's current bit is its last |
| col_shift | output | NUM_COLS | Per-column shift enable, advances the column by one bit |
| ser_out | output | 1 | Serial data bit |
| ser_valid | output | 1 | `ser_out` carries a bit this cycle |
| byte_out | output | 8 | Packed byte for the line encoder |
| byte_valid | output | 1 | `byte_out` valid, one cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle run completion pulse |

## Verification
On every cycle, the assertions check the following: shift enables are spaced at least two cycles apart when k is above one, the captured group width holds during a run, a flush only follows serial output, every byte strobe has a serial bit or flush behind it, and the completion pulse is single and outside busy. Only the bench scenarios can show the rest, because a reference stream is built from the column contents. That covers the exact bit order within a group, the filler zeros and exact shift counts of short columns, group length set by the longest column, MSB-first packing with zero padding, and recovery after reset mid-run.

// File: rtl/colrd_pkg.sv
package colrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_FIN
    } colrd_state_e;

    localparam int BYTE_W = 8;

    // Group width from the two-bit select: 1, 2, 4 or 8 columns.
    function automatic logic [3:0] par_width(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

endpackage

// File: rtl/colrd_sequencer.sv
module colrd_sequencer
    import colrd_pkg::*;
#(
    parameter int NUM_COLS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          par_sel,
    input  logic [NUM_COLS-1:0] col_data,
    input  logic [NUM_COLS-1:0] col_last,
    output logic [NUM_COLS-1:0] col_shift,
    output logic                ser_bit,
    output logic                ser_valid,
    output logic                flush,
    output logic                busy,
    output logic                done
);
    localparam int IDX_W = $clog2(NUM_COLS) + 1;

    colrd_state_e        state;
    logic [3:0]          k_q;
    logic [IDX_W-1:0]    base;
    logic [2:0]          phase;
    logic [NUM_COLS-1:0] fin;
    logic                done_q;

    logic [NUM_COLS-1:0] grp_mask;
    logic [NUM_COLS-1:0] fin_upd;
    logic                period_end;
    logic                grp_clear;
    logic                last_grp;
    logic [IDX_W-1:0]    cur_idx;
    logic                sel_bit;

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_mask
        assign grp_mask[c] = (IDX_W'(c) >= base) && (IDX_W'(c) < base + IDX_W'(k_q));
    end

    assign period_end = (state == ST_RUN) && ({1'b0, phase} == k_q - 4'd1);
    assign fin_upd    = fin | (col_last & grp_mask);
    assign grp_clear  = ((fin_upd & grp_mask) == grp_mask);
    assign last_grp   = (base + IDX_W'(k_q) == IDX_W'(NUM_COLS));
    assign cur_idx    = base + IDX_W'(phase);

    always_comb begin
        sel_bit = 1'b0;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (IDX_W'(c) == cur_idx) begin
                sel_bit = col_data[c] & ~fin[c];
            end
        end
    end

    assign col_shift = period_end ? (grp_mask & ~fin) : '0;
    assign ser_valid = (state == ST_RUN);
    assign ser_bit   = ser_valid & sel_bit;
    assign flush     = (state == ST_FLUSH);
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            k_q    <= 4'd1;
            base   <= '0;
            phase  <= '0;
            fin    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state == ST_FIN);
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        k_q   <= par_width(par_sel);
                        base  <= '0;
                        phase <= '0;
                        fin   <= '0;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (period_end) begin
                        phase <= '0;
                        if (grp_clear) begin
                            fin <= '0;
                            if (last_grp) begin
                                state <= ST_FLUSH;
                            end else begin
                                base <= base + IDX_W'(k_q);
                            end
                        end else begin
                            fin <= fin_upd;
                        end
                    end else begin
                        phase <= phase + 3'd1;
                    end
                end
                ST_FLUSH: state <= ST_FIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R2: with k above one, a shift strobe is never followed by another at once
    assert_shift_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (col_shift != '0 && k_q > 4'd1) |=> (col_shift == '0));

    // R9: the captured group width does not move while a run is in progress
    assert_width_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(k_q));

    // R7: a flush cycle only ever directly follows serial output
    assert_flush_after_run_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flush) |-> $past(ser_valid));

endmodule

// File: rtl/colrd_byte_packer.sv
module colrd_byte_packer
    import colrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_bit,
    input  logic              flush_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid
);
    logic [BYTE_W-1:0] sreg;
    logic [2:0]        cnt;
    logic [BYTE_W-1:0] out_q;
    logic              ov_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            cnt   <= '0;
            out_q <= '0;
            ov_q  <= 1'b0;
        end else begin
            ov_q <= 1'b0;
            if (in_valid) begin
                if (cnt == 3'd7) begin
                    out_q <= {sreg[BYTE_W-2:0], in_bit};
                    ov_q  <= 1'b1;
                    sreg  <= '0;
                    cnt   <= '0;
                end else begin
                    sreg <= {sreg[BYTE_W-2:0], in_bit};
                    cnt  <= cnt + 3'd1;
                end
            end else if (flush_in && cnt != 3'd0) begin
                out_q <= sreg << (4'd8 - {1'b0, cnt});
                ov_q  <= 1'b1;
                sreg  <= '0;
                cnt   <= '0;
            end
        end
    end

    assign byte_out   = out_q;
    assign byte_valid = ov_q;

    // R6: every byte strobe is caused by a serial bit or a flush one cycle earlier
    assert_byte_source_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $past(in_valid || flush_in));

endmodule

// File: rtl/colrd_serializer.sv
module colrd_serializer
    import colrd_pkg::*;
#(
    parameter int NUM_COLS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          par_sel,
    input  logic [NUM_COLS-1:0] col_data,
    input  logic [NUM_COLS-1:0] col_last,
    output logic [NUM_COLS-1:0] col_shift,
    output logic                ser_out,
    output logic                ser_valid,
    output logic [7:0]          byte_out,
    output logic                byte_valid,
    output logic                busy,
    output logic                done
);
    logic flush;

    colrd_sequencer #(.NUM_COLS(NUM_COLS)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .par_sel   (par_sel),
        .col_data  (col_data),
        .col_last  (col_last),
        .col_shift (col_shift),
        .ser_bit   (ser_out),
        .ser_valid (ser_valid),
        .flush     (flush),
        .busy      (busy),
        .done      (done)
    );

    colrd_byte_packer pack_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (ser_valid),
        .in_bit     (ser_out),
        .flush_in   (flush),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion is only signalled once the run has ended
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: tb/colrd_serializer_tb.sv
module colrd_serializer_tb_top;
    localparam int NC     = 16;
    localparam int MAXLEN = 24;
    localparam int MAXB   = NC * MAXLEN + 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    par_sel = 2'd0;
    logic [NC-1:0] col_data = '0;
    logic [NC-1:0] col_last = '0;
    logic [NC-1:0] col_shift;
    logic          ser_out, ser_valid, byte_valid, busy, done;
    logic [7:0]    byte_out;

    colrd_serializer #(.NUM_COLS(NC)) dut_i (
        .clk(clk), .rst(rst), .start(start), .par_sel(par_sel),
        .col_data(col_data), .col_last(col_last), .col_shift(col_shift),
        .ser_out(ser_out), .ser_valid(ser_valid), .byte_out(byte_out),
        .byte_valid(byte_valid), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          col_len [NC];
    bit          col_bits[NC][MAXLEN];
    int          col_ptr [NC];
    logic [NC-1:0] shift_prev = '0;
    bit          exp_bit  [MAXB];
    logic [NC-1:0] exp_shift[MAXB];
    logic [7:0]  exp_byte [MAXB/8 + 2];
    int          n_bits, n_bytes, sidx, bidx;
    int          cyc = 0;
    int          last_sv_cyc = 0;
    bit          running = 1'b0;
    bit          done_seen = 1'b0;
    bit          partial_tail = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int unsigned next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 8;
    endfunction

    // Column model, cycle monitor and reference comparison, all away from the rising edge.
    always @(negedge clk) begin
        cyc++;
        for (int c = 0; c < NC; c++) begin
            if (shift_prev[c]) col_ptr[c]++;
            col_data[c] = (col_ptr[c] < col_len[c]) ? col_bits[c][col_ptr[c]] : 1'b0;
            col_last[c] = (col_ptr[c] == col_len[c] - 1);
        end
        #1;
        if (!rst && running) begin
            if (ser_valid) begin
                if (sidx < n_bits) begin
                    chk(ser_out == exp_bit[sidx], "R3 serial bit order", 32'(ser_out), 32'(exp_bit[sidx]));
                    chk(col_shift == exp_shift[sidx], "R2 shift strobe", 32'(col_shift), 32'(exp_shift[sidx]));
                end else begin
                    chk(1'b0, "R5 serial bit beyond group length", 32'(sidx), 32'(n_bits));
                end
                sidx++;
                last_sv_cyc = cyc;
            end else begin
                chk(col_shift == '0, "R2 shift outside run", 32'(col_shift), 32'd0);
            end
            if (byte_valid) begin
                if (bidx < n_bytes) begin
                    if (partial_tail && bidx == n_bytes - 1)
                        chk(byte_out == exp_byte[bidx], "R7 padded byte", 32'(byte_out), 32'(exp_byte[bidx]));
                    else
                        chk(byte_out == exp_byte[bidx], "R6 packed byte", 32'(byte_out), 32'(exp_byte[bidx]));
                end else begin
                    chk(1'b0, "R7 extra byte", 32'(bidx), 32'(n_bytes));
                end
                bidx++;
            end
            if (done) begin
                chk(cyc == last_sv_cyc + 3, "R8 done timing", 32'(cyc - last_sv_cyc), 32'd3);
                chk(!busy, "R8 busy low at done", 32'(busy), 32'd0);
                chk(bidx == n_bytes, "R7 bytes before done", 32'(bidx), 32'(n_bytes));
                chk(sidx == n_bits, "R5 total serial length", 32'(sidx), 32'(n_bits));
                done_seen = 1'b1;
            end
        end
        shift_prev = col_shift;
    end

    // Build column contents and the expected streams for one run.
    task automatic setup(input int k, input int mode);
        int n;
        int acc;
        int nacc;
        logic [NC-1:0] m;
        @(posedge clk);
        #2;
        for (int c = 0; c < NC; c++) begin
            col_ptr[c] = 0;
            if (mode == 1) col_len[c] = 8;
            else if (mode == 2) col_len[c] = (c == 5) ? MAXLEN : 1 + int'(next_rand() % 3);
            else col_len[c] = 1 + int'(next_rand() % MAXLEN);
            for (int i = 0; i < MAXLEN; i++) col_bits[c][i] = next_rand()[3];
        end
        shift_prev = '0;
        n = 0;
        for (int base = 0; base < NC; base += k) begin
            int lmax;
            lmax = 0;
            for (int q = base; q < base + k; q++) if (col_len[q] > lmax) lmax = col_len[q];
            for (int i = 0; i < lmax; i++) begin
                for (int p = 0; p < k; p++) begin
                    exp_bit[n] = (i < col_len[base+p]) ? col_bits[base+p][i] : 1'b0;
                    m = '0;
                    if (p == k - 1)
                        for (int q = base; q < base + k; q++) if (i < col_len[q]) m[q] = 1'b1;
                    exp_shift[n] = m;
                    n++;
                end
            end
        end
        n_bits = n;
        n_bytes = 0;
        acc = 0;
        nacc = 0;
        for (int i = 0; i < n_bits; i++) begin
            acc = (acc << 1) | int'(exp_bit[i]);
            nacc++;
            if (nacc == 8) begin
                exp_byte[n_bytes] = 8'(acc);
                n_bytes++;
                acc = 0;
                nacc = 0;
            end
        end
        partial_tail = (nacc != 0);
        if (nacc != 0) begin
            exp_byte[n_bytes] = 8'(acc << (8 - nacc));
            n_bytes++;
        end
        sidx = 0;
        bidx = 0;
        done_seen = 1'b0;
        running = 1'b1;
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        #2;
        chk(!busy, req, 32'(busy), 32'd0);
        chk(!done && !ser_valid && !byte_valid, req, {29'd0, done, ser_valid, byte_valid}, 32'd0);
        chk(col_shift == '0, req, 32'(col_shift), 32'd0);
    endtask

    task automatic run_case(input logic [1:0] sel, input int mode, input bit disturb);
        int k;
        int waited;
        k = 1 << sel;
        setup(k, mode);
        @(negedge clk);
        par_sel = sel;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R9: a second start and a new width while busy must change nothing
            repeat (7) @(negedge clk);
            start = 1'b1;
            par_sel = ~sel;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done_seen && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_seen, "R8 run completed", 32'(done_seen), 32'd1);
        @(negedge clk);
        #2;
        chk(sidx == n_bits, "R5 serial bit count", 32'(sidx), 32'(n_bits));
        for (int c = 0; c < NC; c++)
            chk(col_ptr[c] == col_len[c], "R4 shifts per column", 32'(col_ptr[c]), 32'(col_len[c]));
        running = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R10 reset state");
        run_case(2'd0, 0, 1'b0);   // R1 one column at a time
        run_case(2'd1, 0, 1'b0);   // R1 pairs
        run_case(2'd2, 2, 1'b0);   // R5 one long column sets group length
        run_case(2'd3, 0, 1'b0);   // R1 eight at once
        run_case(2'd3, 1, 1'b0);   // R7 no padding when bits fill whole bytes
        run_case(2'd1, 0, 1'b1);   // R9 start ignored while busy
        // R10: abort mid-run, then a clean run must start from column 0 with an empty packer
        setup(4, 0);
        @(negedge clk);
        par_sel = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (13) @(negedge clk);
        running = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_idle("R10 idle after mid-run reset");
        run_case(2'd2, 0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule